// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and an asynchronous static RAM with a 16-bit data bus, two chip selects (one active low, one active high), an active-low write strobe, an active-low output enable and two active-low byte lanes. The host issues one request at a time through a valid/ready handshake. A request carries a write flag, an address, write data and a two-bit byte mask. The controller turns each request into a pin sequence whose every interval is a whole number of system-clock cycles. The cycle counts come from nanosecond parameters rounded up at elaboration.

A read holds the chip selected with the output enabled until the slowest of the cycle time, the address access time and the output-enable access time has passed. It then captures the bus and returns the word with a single-cycle valid pulse. A write first presents the address, the byte lanes and the data, then pulses the write strobe, then raises the strobe while everything else is still held. After every read the controller waits out the memory's output turn-off time before it accepts a new request. This guarantees that it never drives the bus while the memory may still be driving it.

Top module: `sram_pace_ctrl`

## Requirements
- R1: While reset is asserted and right after it, req_ready is 1, sram_ce_n=1, sram_ce2=0, sram_we_n=1, sram_oe_n=1, sram_lb_n=1, sram_ub_n=1, sram_dq_oe=0 and rd_valid=0.
- R2: req_ready is 1 only when no operation or recovery is in progress. A request is taken at a rising edge where req_valid and req_ready are both 1. While req_ready is 0, req_valid and the request fields have no effect on the pins. When idle, every strobe is inactive and the bus is not driven.
- R3: A read occupies RD = max(ceil(T_RC/CLK_NS), ceil(T_AA/CLK_NS), ceil(T_OE/CLK_NS)) cycles (6 by default), starting in the cycle after acceptance. In those cycles sram_ce_n=0, sram_ce2=1, sram_oe_n=0, sram_we_n=1 and sram_dq_oe=0, with the request address on sram_addr.
- R4: rd_data takes the value of sram_dq_in at the clock edge that ends the last read access cycle. rd_valid is 1 for exactly the one following cycle.
- R5: During every active cycle of an operation, sram_lb_n equals the inverse of mask bit 0 and sram_ub_n equals the inverse of mask bit 1. Bit 0 governs data bits 7:0 and bit 1 governs bits 15:8. Outside operations both are 1.
- R6: A write is one setup cycle with the chip selected and sram_we_n=1, then WP = max(ceil(T_WP/CLK_NS), ceil(T_DW/CLK_NS), ceil(T_WC/CLK_NS)-2) cycles with sram_we_n=0 (5 by default), then one end cycle with sram_we_n=1 and the chip still selected. After that the controller is idle.
- R7: sram_dq_oe is 1 exactly in the setup, strobe and end cycles of a write, so it is never 1 while sram_oe_n=0.
- R8: Each read is followed by OHZ = ceil(T_OHZ/CLK_NS) recovery cycles (3 by default). In these cycles all strobes are inactive, the bus is not driven and req_ready is 0.
- R9: sram_addr stays stable while the chip is selected, and sram_dq_out stays stable while sram_dq_oe is 1, both holding the accepted request's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Captured read word |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lb_n | output | 1 | Active-low low-byte lane |
| sram_ub_n | output | 1 | Active-low high-byte lane |
| sram_addr | output | AW | Memory address |
| sram_dq_out | output | 16 | Data driven towards memory |
| sram_dq_oe | output | 1 | Bus drive enable |
| sram_dq_in | input | 16 | Data returned by memory |

## Verification
With defaults, a read accepted at edge N holds the read strobes for the next six cycles and raises rd_valid in the seventh, followed by three recovery cycles. A write accepted at edge N has its setup cycle right after, the strobe low for five cycles, one end cycle, and req_ready back in the eighth cycle. The bench derives each request's cycle-by-cycle pin vector from these counts when the request is accepted, queues the vectors, and compares one per cycle at the falling edge, half a period after the registers have settled. The bench's memory model returns poison data until the access has lasted the full access time in nanoseconds, so a capture taken even one cycle early shows up in rd_data.

// File: rtl/sram_pace_ctrl.sv
module sram_pace_ctrl #(
  parameter int AW     = 20,
  parameter int CLK_NS = 8,
  parameter int T_RC   = 45,
  parameter int T_AA   = 45,
  parameter int T_OE   = 30,
  parameter int T_WC   = 45,
  parameter int T_WP   = 35,
  parameter int T_DW   = 25,
  parameter int T_OHZ  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_lb_n,
  output logic          sram_ub_n,
  output logic [AW-1:0] sram_addr,
  output logic [15:0]   sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [15:0]   sram_dq_in
);

  function automatic int cdiv(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = imax(imax(cdiv(T_RC), cdiv(T_AA)), imax(cdiv(T_OE), 1));
  localparam int WP_CYC  = imax(imax(cdiv(T_WP), cdiv(T_DW)), imax(cdiv(T_WC) - 2, 1));
  localparam int OHZ_CYC = imax(cdiv(T_OHZ), 1);
  localparam int MAXC    = imax(RD_CYC, imax(WP_CYC, OHZ_CYC));
  localparam int CW      = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WPUL, S_WEND, S_TURN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [15:0]   d_q;
  logic [1:0]    be_q;
  logic          active;
  logic          wr_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      a_q      <= '0;
      d_q      <= '0;
      be_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          d_q   <= req_wdata;
          be_q  <= req_be;
          cnt   <= '0;
          state <= req_write ? S_WSET : S_RD;
        end
        S_RD: if (cnt == CW'(RD_CYC - 1)) begin
          rd_data  <= sram_dq_in;
          rd_valid <= 1'b1;
          cnt      <= '0;
          state    <= S_TURN;
        end else cnt <= cnt + 1'b1;
        S_WSET: begin
          cnt   <= '0;
          state <= S_WPUL;
        end
        S_WPUL: if (cnt == CW'(WP_CYC - 1)) state <= S_WEND;
                else cnt <= cnt + 1'b1;
        S_WEND: state <= S_IDLE;
        S_TURN: if (cnt == CW'(OHZ_CYC - 1)) state <= S_IDLE;
                else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_phase    = (state == S_WSET) || (state == S_WPUL) || (state == S_WEND);
  assign active      = wr_phase || (state == S_RD);
  assign req_ready   = (state == S_IDLE);
  assign sram_ce_n   = ~active;
  assign sram_ce2    = active;
  assign sram_oe_n   = ~(state == S_RD);
  assign sram_we_n   = ~(state == S_WPUL);
  assign sram_lb_n   = ~(active & be_q[0]);
  assign sram_ub_n   = ~(active & be_q[1]);
  assign sram_addr   = a_q;
  assign sram_dq_out = d_q;
  assign sram_dq_oe  = wr_phase;

endmodule

// File: rtl/sram_pace_ctrl_chk.sv
module sram_pace_ctrl_chk #(
  parameter int AW     = 20,
  parameter int CLK_NS = 8,
  parameter int T_WC   = 45,
  parameter int T_WP   = 35,
  parameter int T_DW   = 25,
  parameter int T_OHZ  = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          sram_ce_n,
  input logic          sram_ce2,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [AW-1:0] sram_addr,
  input logic [15:0]   sram_dq_out,
  input logic          sram_dq_oe
);
  localparam int P_WP0 = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int P_DW  = (T_DW + CLK_NS - 1) / CLK_NS;
  localparam int P_WC2 = (T_WC + CLK_NS - 1) / CLK_NS - 2;
  localparam int P_WPA = (P_WP0 > P_DW) ? P_WP0 : P_DW;
  localparam int P_WPB = (P_WC2 > 1) ? P_WC2 : 1;
  localparam int P_WP  = (P_WPA > P_WPB) ? P_WPA : P_WPB;
  localparam int P_OHZ0 = (T_OHZ + CLK_NS - 1) / CLK_NS;
  localparam int P_OHZ  = (P_OHZ0 > 1) ? P_OHZ0 : 1;

  logic [7:0] we_low;
  logic [7:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low   <= '0;
      since_oe <= 8'hFF;
    end else begin
      we_low   <= sram_we_n ? 8'd0 : we_low + 8'd1;
      since_oe <= !sram_oe_n ? 8'd0 : ((since_oe == 8'hFF) ? since_oe : since_oe + 8'd1);
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));
  assert_no_bus_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  assert_we_under_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce2 && sram_dq_oe));
  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low == 8'(P_WP)));
  assert_we_before_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |-> $past(sram_we_n));
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_rd_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!sram_oe_n));
  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_oe >= 8'(P_OHZ)));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));
endmodule

bind sram_pace_ctrl sram_pace_ctrl_chk #(
  .AW(AW), .CLK_NS(CLK_NS), .T_WC(T_WC), .T_WP(T_WP), .T_DW(T_DW), .T_OHZ(T_OHZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_pace_ctrl_tb.sv
module sram_pace_ctrl_tb;
  localparam int AW = 20;
  localparam int CK = 8;
  localparam int B_RD  = 6;
  localparam int B_WP  = 5;
  localparam int B_OHZ = 3;
  localparam int AA_NS = 45;
  localparam int OE_NS = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid;
  logic [15:0] rd_data;
  logic sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
  logic [AW-1:0] sram_addr;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in = 16'hBAD0;

  always #4 clk = ~clk;

  sram_pace_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n),
    .sram_ub_n(sram_ub_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  typedef struct {
    logic [1:0]  kind;
    logic        ce, oe, we, dqoe, rdv, lb_n, ub_n;
    logic [19:0] addr;
    logic [15:0] wd, rd;
  } exp_t;

  exp_t q[$];
  exp_t e, idle_e;
  logic [15:0] sram_mem [64];
  logic [15:0] ref_mem [64];
  int n_chk = 0, n_fail = 0, acc_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, expv);
    end
  endtask

  function automatic string ktag(input logic [1:0] k);
    case (k)
      2'd1: return "R3";
      2'd2: return "R6";
      2'd3: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      sram_mem[i] = 16'(i * 257) ^ 16'h5A3C;
      ref_mem[i]  = 16'(i * 257) ^ 16'h5A3C;
    end
    idle_e = '{kind: 2'd0, ce: 1'b0, oe: 1'b0, we: 1'b0, dqoe: 1'b0, rdv: 1'b0,
               lb_n: 1'b1, ub_n: 1'b1, addr: 20'h0, wd: 16'h0, rd: 16'h0};
  end

  // Reference model: sequence pushed at acceptance, one vector per cycle
  always @(posedge clk) if (rst_n) begin
    exp_t s;
    bit acc;
    logic [5:0] ai;
    acc = req_valid && (q.size() == 0);
    if (q.size() > 0) void'(q.pop_front());
    if (acc) begin
      ai = req_addr[5:0];
      s = idle_e;
      s.addr = req_addr;
      s.lb_n = ~req_be[0];
      s.ub_n = ~req_be[1];
      s.ce = 1'b1;
      if (req_write) begin
        s.kind = 2'd2; s.dqoe = 1'b1; s.wd = req_wdata;
        q.push_back(s);
        s.we = 1'b1;
        for (int k = 0; k < B_WP; k++) q.push_back(s);
        s.we = 1'b0;
        q.push_back(s);
        if (req_be[0]) ref_mem[ai][7:0]  = req_wdata[7:0];
        if (req_be[1]) ref_mem[ai][15:8] = req_wdata[15:8];
      end else begin
        s.kind = 2'd1; s.oe = 1'b1;
        for (int k = 0; k < B_RD; k++) q.push_back(s);
        s = idle_e;
        s.kind = 2'd3;
        s.rd = {req_be[1] ? ref_mem[ai][15:8] : 8'h00, req_be[0] ? ref_mem[ai][7:0] : 8'h00};
        for (int k = 0; k < B_OHZ; k++) begin
          s.rdv = (k == 0);
          q.push_back(s);
        end
      end
    end
  end

  // Memory model: data valid only once the access has lasted long enough
  always @(negedge clk) if (rst_n) begin
    logic [5:0] mi;
    mi = sram_addr[5:0];
    if (!sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n) acc_cnt++;
    else acc_cnt = 0;
    if (acc_cnt * CK >= AA_NS && acc_cnt * CK >= OE_NS)
      sram_dq_in = {sram_ub_n ? 8'h00 : sram_mem[mi][15:8], sram_lb_n ? 8'h00 : sram_mem[mi][7:0]};
    else
      sram_dq_in = 16'hBAD0;
    if (!sram_we_n && !sram_ce_n && sram_ce2) begin
      if (!sram_lb_n) sram_mem[mi][7:0]  = sram_dq_out[7:0];
      if (!sram_ub_n) sram_mem[mi][15:8] = sram_dq_out[15:8];
    end
  end

  // Per-cycle comparison, half a period after the edge
  always @(negedge clk) if (rst_n) begin
    e = (q.size() > 0) ? q[0] : idle_e;
    chk(req_ready == (q.size() == 0), "R2 ready", 32'(req_ready), 32'(q.size() == 0));
    chk({sram_ce_n, sram_ce2, sram_oe_n} == {~e.ce, e.ce, ~e.oe}, ktag(e.kind),
        32'({sram_ce_n, sram_ce2, sram_oe_n}), 32'({~e.ce, e.ce, ~e.oe}));
    chk(sram_we_n == ~e.we, (e.kind == 2'd2) ? "R6 we" : ktag(e.kind), 32'(sram_we_n), 32'(~e.we));
    chk({sram_ub_n, sram_lb_n} == {e.ub_n, e.lb_n}, "R5 lanes",
        32'({sram_ub_n, sram_lb_n}), 32'({e.ub_n, e.lb_n}));
    chk(sram_dq_oe == e.dqoe, "R7 drive", 32'(sram_dq_oe), 32'(e.dqoe));
    chk(rd_valid == e.rdv, "R4 valid", 32'(rd_valid), 32'(e.rdv));
    if (e.rdv) chk(rd_data == e.rd, "R4 data", 32'(rd_data), 32'(e.rd));
    if (e.ce) chk(sram_addr == e.addr, "R9 addr", 32'(sram_addr), 32'(e.addr));
    if (e.dqoe) chk(sram_dq_out == e.wd, "R9 data", 32'(sram_dq_out), 32'(e.wd));
  end

  task automatic do_req(input bit w, input logic [5:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = w; req_addr = {14'h0, a}; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = 20'hFFFFF; req_wdata = 16'hFFFF; req_be = 2'b11; req_write = ~w;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk(req_ready && sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && sram_lb_n &&
        sram_ub_n && !sram_dq_oe && !rd_valid, "R1 reset",
        32'({req_ready, sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, rd_valid}),
        32'(9'b110111100));
    rst_n = 1'b1;
    gap(2);
    // R6 full write, R3/R4 read back
    do_req(1'b1, 6'd5, 16'hA5C3, 2'b11); gap(10);
    do_req(1'b0, 6'd5, 16'h0, 2'b11); gap(12);
    // R5 lane masks on write and read
    do_req(1'b1, 6'd5, 16'h1234, 2'b01); gap(9);
    do_req(1'b0, 6'd5, 16'h0, 2'b11); gap(11);
    do_req(1'b1, 6'd7, 16'h9876, 2'b10);
    do_req(1'b0, 6'd7, 16'h0, 2'b10);
    do_req(1'b0, 6'd5, 16'h0, 2'b01);
    // R2 back-pressure and R8 recovery: chained requests while busy
    do_req(1'b0, 6'd9, 16'h0, 2'b11);
    do_req(1'b1, 6'd9, 16'hC0DE, 2'b11);
    do_req(1'b0, 6'd9, 16'h0, 2'b11);
    do_req(1'b1, 6'd10, 16'h0F0F, 2'b00);
    do_req(1'b0, 6'd10, 16'h0, 2'b11);
    gap(12);
    r = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      do_req(r[17], r[23:18], r[15:0], r[25:24]);
      if (r[28]) gap(32'(r[31:29]));
    end
    gap(16);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule